// File: doc/BRIEF.md
# Self-Synchronous Octet Lane Scrambler and Descrambler

This block holds the two halves of a line scrambler for one high-speed serial lane. Each half takes one octet per clock. The transmit half scrambles user octets with the polynomial 1 + x^14 + x^15 before they go out on the line. The receive half undoes that scrambling. The goal is to spread the line spectrum so that repeated data patterns do not produce strong spectral peaks.

The scrambler is self-synchronous. The receive half needs no seed exchange: it rebuilds the transmit state from the line bits it receives, even though the two halves leave reset with different register contents. Both halves start work on the first user octet, which is marked by a start strobe. Every octet before that point, during lane alignment, passes through unchanged. A bypass control on each half makes it pass data straight through.

Each half has a valid/ready stream on its input and its output. The datapath is combinational, so there is no buffering inside the block. The output valid follows the input valid, and the input ready follows the output ready. An octet moves only in a cycle where both valid and ready are high. While an octet is stalled (valid high, ready low), the upstream source must hold the octet and its start strobe. The block then keeps the output octet stable.

Top module: `lane_scrambler_pair`

## Requirements
- R1: For each half, out_valid equals in_valid and in_ready equals out_ready in every cycle, including during reset. An octet transfers in a cycle where in_valid and out_ready are both high.
- R2: Until an octet with the start strobe set has transferred, each half copies in_data to out_data unchanged, and its shift register does not change.
- R3: After the start, the transmit half produces each line bit as d ^ s(n-14) ^ s(n-15). Here s is the sequence of past line bits. Bits are taken MSB first, and bit 7 of an octet precedes bit 0. The octet that carries the start strobe is the first octet scrambled. The transmit register leaves reset holding all ones.
- R4: After the start, the receive half produces each output bit as e ^ e(n-14) ^ e(n-15). Here e is the sequence of received line bits, taken MSB first. The receive register leaves reset holding all zeros.
- R5: When both halves are chained and have the same bypass setting, the receive output equals the transmit input from the third user octet onward.
- R6: A shift register advances only on a transfer. Stalled cycles and cycles without valid data leave it unchanged.
- R7: While a half's effective bypass is 1, out_data equals in_data. Its register still takes in the line bits, so that chained halves stay in step.
- R8: The bypass input is captured at each clock edge unless an octet is stalled. The captured value takes effect on the next octet. While an octet is stalled with its data held, out_data stays unchanged.
- R9: The start strobe counts only in a transfer cycle. A strobe raised without valid data does not start scrambling. Once started, a half keeps scrambling until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_bypass | input | 1 | Transmit half passes data unchanged |
| tx_in_valid | input | 1 | Transmit input octet valid |
| tx_in_ready | output | 1 | Transmit input may transfer |
| tx_in_data | input | W | Transmit input octet |
| tx_in_start | input | 1 | Marks the first user octet on the transmit side |
| tx_out_valid | output | 1 | Line octet valid |
| tx_out_ready | input | 1 | Line sink ready |
| tx_out_data | output | W | Line octet (scrambled) |
| rx_bypass | input | 1 | Receive half passes data unchanged |
| rx_in_valid | input | 1 | Received line octet valid |
| rx_in_ready | output | 1 | Receive input may transfer |
| rx_in_data | input | W | Received line octet |
| rx_in_start | input | 1 | Marks the first user octet on the receive side |
| rx_out_valid | output | 1 | Recovered octet valid |
| rx_out_ready | input | 1 | Recovered-data sink ready |
| rx_out_data | output | W | Recovered octet |

## Verification
The stall-stability properties depend on the upstream source holding the octet and its start strobe for as long as a transfer is refused. The bench guarantees this by presenting every octet through one task that repeats the same values until the octet fires. The pass-through properties keep their own record of whether a start has transferred and of the bypass value held at the last edge. They therefore rely only on the start strobe being honoured with a transfer. The bench also raises the strobe once without valid data to show that this case is ignored. The bypass inputs are changed both in free-running cycles and in the middle of a stall, so both capture paths are covered.

// File: rtl/lane_scr_pkg.sv
package lane_scr_pkg;
  typedef enum logic { MODE_SCR = 1'b0, MODE_DESCR = 1'b1 } scr_mode_e;
endpackage

// File: rtl/lane_scr_gate.sv
// Per-half control: start tracking, bypass capture, transfer detection.
module lane_scr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  input  logic start,
  input  logic byp_req,
  output logic fire,
  output logic scr_on,
  output logic byp
);
  logic live_q, byp_q, stalled;

  assign fire    = in_valid && out_ready;
  assign stalled = in_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      if (fire && start) live_q <= 1'b1;
      if (!stalled)      byp_q  <= byp_req;
    end
  end

  assign scr_on = live_q || start;
  assign byp    = byp_q;
endmodule

// File: rtl/lane_scr_lfsr.sv
// Octet-wide self-synchronous LFSR, MSB first; MODE picks the feedback source.
module lane_scr_lfsr import lane_scr_pkg::*; #(
  parameter int        W    = 8,
  parameter int        LEN  = 15,
  parameter int        TAP  = 14,
  parameter scr_mode_e MODE = MODE_SCR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         byp,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [LEN-1:0] INIT = (MODE == MODE_SCR) ? {LEN{1'b1}} : {LEN{1'b0}};

  logic [LEN-1:0] st_q, st_d;

  always_comb begin
    logic [LEN-1:0] s;
    logic           fb, o, line;
    s    = st_q;
    dout = '0;
    for (int i = W - 1; i >= 0; i--) begin
      fb      = s[TAP-1] ^ s[LEN-1];
      o       = din[i] ^ fb;
      dout[i] = o;
      // the register always follows the bits on the line
      line    = (MODE == MODE_SCR && !byp) ? o : din[i];
      s       = {s[LEN-2:0], line};
    end
    st_d = s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   st_q <= INIT;
    else if (adv) st_q <= st_d;
  end
endmodule

// File: rtl/lane_scr_path.sv
// One direction: gate + LFSR + output select, combinational valid/ready.
module lane_scr_path import lane_scr_pkg::*; #(
  parameter int        W    = 8,
  parameter int        LEN  = 15,
  parameter int        TAP  = 14,
  parameter scr_mode_e MODE = MODE_SCR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bypass,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_start,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         fire, scr_on, byp;
  logic [W-1:0] mixed;

  lane_scr_gate i_gate (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .start(in_start), .byp_req(bypass), .fire(fire), .scr_on(scr_on), .byp(byp)
  );

  lane_scr_lfsr #(.W(W), .LEN(LEN), .TAP(TAP), .MODE(MODE)) i_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(fire && scr_on), .byp(byp),
    .din(in_data), .dout(mixed)
  );

  assign out_data  = (scr_on && !byp) ? mixed : in_data;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;
endmodule

// File: rtl/lane_scrambler_pair.sv
module lane_scrambler_pair import lane_scr_pkg::*; #(
  parameter int W   = 8,
  parameter int LEN = 15,
  parameter int TAP = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_bypass,
  input  logic         tx_in_valid,
  output logic         tx_in_ready,
  input  logic [W-1:0] tx_in_data,
  input  logic         tx_in_start,
  output logic         tx_out_valid,
  input  logic         tx_out_ready,
  output logic [W-1:0] tx_out_data,
  input  logic         rx_bypass,
  input  logic         rx_in_valid,
  output logic         rx_in_ready,
  input  logic [W-1:0] rx_in_data,
  input  logic         rx_in_start,
  output logic         rx_out_valid,
  input  logic         rx_out_ready,
  output logic [W-1:0] rx_out_data
);
  lane_scr_path #(.W(W), .LEN(LEN), .TAP(TAP), .MODE(MODE_SCR)) i_tx (
    .clk(clk), .rst_n(rst_n), .bypass(tx_bypass),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .in_start(tx_in_start), .out_valid(tx_out_valid), .out_ready(tx_out_ready),
    .out_data(tx_out_data)
  );

  lane_scr_path #(.W(W), .LEN(LEN), .TAP(TAP), .MODE(MODE_DESCR)) i_rx (
    .clk(clk), .rst_n(rst_n), .bypass(rx_bypass),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .in_start(rx_in_start), .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .out_data(rx_out_data)
  );
endmodule

// File: rtl/lane_scr_checker.sv
module lane_scr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tx_bypass,
  input logic         tx_in_valid,
  input logic [W-1:0] tx_in_data,
  input logic         tx_in_start,
  input logic         tx_out_ready,
  input logic [W-1:0] tx_out_data,
  input logic         rx_bypass,
  input logic         rx_in_valid,
  input logic [W-1:0] rx_in_data,
  input logic         rx_in_start,
  input logic         rx_out_ready,
  input logic [W-1:0] rx_out_data
);
  logic tx_seen, rx_seen, tx_byp_m, rx_byp_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_seen <= 1'b0; rx_seen <= 1'b0; tx_byp_m <= 1'b0; rx_byp_m <= 1'b0;
    end else begin
      if (tx_in_valid && tx_out_ready && tx_in_start) tx_seen <= 1'b1;
      if (rx_in_valid && rx_out_ready && rx_in_start) rx_seen <= 1'b1;
      if (!(tx_in_valid && !tx_out_ready)) tx_byp_m <= tx_bypass;
      if (!(rx_in_valid && !rx_out_ready)) rx_byp_m <= rx_bypass;
    end
  end

  a_r2_tx_align_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_seen && !tx_in_start) |-> tx_out_data == tx_in_data);
  a_r2_rx_align_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_seen && !rx_in_start) |-> rx_out_data == rx_in_data);
  a_r7_tx_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_byp_m) |-> tx_out_data == tx_in_data);
  a_r7_rx_bypass_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_byp_m) |-> rx_out_data == rx_in_data);
  a_r8_tx_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && !tx_out_ready) |=>
      (!(tx_in_valid && $stable(tx_in_data) && $stable(tx_in_start)) || $stable(tx_out_data)));
  a_r8_rx_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && !rx_out_ready) |=>
      (!(rx_in_valid && $stable(rx_in_data) && $stable(rx_in_start)) || $stable(rx_out_data)));
endmodule

bind lane_scrambler_pair lane_scr_checker #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .tx_bypass(tx_bypass), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
  .tx_in_start(tx_in_start), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
  .rx_bypass(rx_bypass), .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
  .rx_in_start(rx_in_start), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
);

// File: tb/test_lane_scrambler_pair.sv
module test_lane_scrambler_pair;
  localparam int W = 8;
  localparam int LEN = 15;
  localparam int TAP = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_bypass = 1'b0, rx_bypass = 1'b0;
  logic tx_in_valid = 1'b0, tx_in_start = 1'b0, rx_out_ready = 1'b0;
  logic [W-1:0] tx_in_data = '0;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [W-1:0] tx_out_data, rx_out_data;

  always #10 clk = ~clk; // 50 MHz

  // transmit output loops straight into the receive input
  lane_scrambler_pair #(.W(W), .LEN(LEN), .TAP(TAP)) i_lane_scrambler_pair (
    .clk(clk), .rst_n(rst_n),
    .tx_bypass(tx_bypass), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_in_start(tx_in_start),
    .tx_out_valid(tx_out_valid), .tx_out_ready(rx_in_ready), .tx_out_data(tx_out_data),
    .rx_bypass(rx_bypass), .rx_in_valid(tx_out_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(tx_out_data), .rx_in_start(tx_in_start),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural reference state
  bit txh[$], rxh[$];
  bit live, tx_byp_e, rx_byp_e, last_fire, prev_stall;
  int user_idx;
  logic [W-1:0] prev_tx_out;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    txh = {}; rxh = {};
    for (int i = 0; i < LEN; i++) begin txh.push_back(1'b1); rxh.push_back(1'b0); end
    live = 0; tx_byp_e = 0; rx_byp_e = 0; user_idx = 0; prev_stall = 0;
  endtask

  // inputs are already set (after a negedge); check, then take the edge
  task automatic step_cycle();
    logic [W-1:0] d, line, rxo;
    bit t[$], r[$];
    bit fb, on, fire, stall;
    string tt, rt;
    d = tx_in_data; on = live || tx_in_start;
    fire = tx_in_valid && rx_out_ready; stall = tx_in_valid && !rx_out_ready;
    t = txh; r = rxh;
    for (int i = W - 1; i >= 0; i--) begin
      fb = t[TAP-1] ^ t[LEN-1];
      line[i] = (on && !tx_byp_e) ? (d[i] ^ fb) : d[i];
      t.push_front(line[i]); void'(t.pop_back());
      fb = r[TAP-1] ^ r[LEN-1];
      rxo[i] = (on && !rx_byp_e) ? (line[i] ^ fb) : line[i];
      r.push_front(line[i]); void'(r.pop_back());
    end
    #2;
    chk(tx_out_valid == tx_in_valid && rx_out_valid == tx_in_valid, "R1 valid",
        {7'd0, tx_out_valid}, {7'd0, tx_in_valid});
    chk(tx_in_ready == rx_out_ready, "R1 ready", {7'd0, tx_in_ready}, {7'd0, rx_out_ready});
    if (tx_in_valid) begin
      tt = !on ? "R2 tx" : (tx_byp_e ? "R7 tx" : (prev_stall ? "R6 tx" : "R3 tx"));
      rt = !on ? "R2 rx" : (rx_byp_e ? "R7 rx" : (prev_stall ? "R6 rx" : "R4 rx"));
      chk(tx_out_data == line, tt, tx_out_data, line);
      chk(rx_out_data == rxo, rt, rx_out_data, rxo);
      if (prev_stall) chk(tx_out_data == prev_tx_out, "R8 hold", tx_out_data, prev_tx_out);
      if (fire && on && tx_byp_e == rx_byp_e && user_idx >= 2)
        chk(rx_out_data == d, "R5 converge", rx_out_data, d);
    end
    prev_stall = stall && (prev_stall || 1'b1);
    prev_tx_out = tx_out_data;
    @(posedge clk);
    if (fire && on) begin txh = t; rxh = r; user_idx++; end
    if (fire && tx_in_start) live = 1;
    if (!stall) begin tx_byp_e = tx_bypass; rx_byp_e = rx_bypass; end
    last_fire = fire;
    @(negedge clk);
  endtask

  // present one octet until it transfers; ready stalls with probability stall_pct
  task automatic send(input logic [W-1:0] d, input bit st, input int stall_pct);
    tx_in_valid = 1; tx_in_data = d; tx_in_start = st;
    do begin
      rx_out_ready = ($urandom_range(99) >= stall_pct);
      step_cycle();
    end while (!last_fire);
    tx_in_valid = 0; tx_in_start = 0;
  endtask

  task automatic idle(input int n);
    tx_in_valid = 0; rx_out_ready = 1;
    for (int i = 0; i < n; i++) step_cycle();
  endtask

  task automatic do_reset();
    rst_n = 0; tx_in_valid = 0; tx_in_start = 0; rx_out_ready = 0;
    @(negedge clk); @(negedge clk);
    #2;
    chk(tx_out_valid == 0 && rx_out_valid == 0, "R1 reset valid", {7'd0, tx_out_valid}, 8'h00);
    chk(tx_in_ready == 0, "R1 reset ready", {7'd0, tx_in_ready}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    reset_model();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // alignment phase (R2), start strobe without valid (R9)
    send(8'hBC, 0, 0); send(8'h1C, 0, 30); send(8'h7C, 0, 0);
    tx_in_start = 1; tx_in_valid = 0; rx_out_ready = 1; step_cycle(); tx_in_start = 0;
    send(8'hFC, 0, 0); // R9: still unscrambled
    idle(2);
    // first user octet is zero against the all-ones start (R3)
    send(8'h00, 1, 0);
    for (int i = 0; i < 40; i++) begin
      send(W'($urandom), 0, 25);
      if (i % 7 == 3) idle(1); // gaps must not advance (R6)
    end
    // bypass change while stalled (R8), then bypass run (R7)
    tx_in_valid = 1; tx_in_data = 8'h5A; rx_out_ready = 0; step_cycle();
    tx_bypass = 1; rx_bypass = 1; step_cycle(); step_cycle();
    send(8'h5A, 0, 0);
    for (int i = 0; i < 10; i++) send(W'($urandom), 0, 20);
    tx_bypass = 0; rx_bypass = 0;
    for (int i = 0; i < 10; i++) send(W'($urandom), 0, 20);
    // receive-only bypass exposes the line octets
    rx_bypass = 1;
    for (int i = 0; i < 6; i++) send(W'($urandom), 0, 0);
    rx_bypass = 0;
    for (int i = 0; i < 20; i++) send(8'h00, 0, 10);
    // reset mid-stream: alignment pass-through returns, then a fresh start
    do_reset();
    send(8'hBC, 0, 0); send(8'h3C, 0, 0);
    send(8'hFF, 1, 0);
    for (int i = 0; i < 30; i++) send(W'($urandom), 0, 30);
    idle(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule